// File: doc/BRIEF.md
# Frame Skip, Mute and Pause Controller

This controller sits between a byte-wide register port and a frame-based audio decode pipeline. It holds a run bit, a command byte and an 8-bit count. At every frame boundary it picks the treatment for the coming frame. The choices are: decode it normally, decode it with a soft-mute request, discard whole frames, stall the decoder for a number of block ticks, or hold the decoder stopped for as long as a pause bit stays set. The decoder datapath and the mute ramp are outside this block.

The controller is a five-state machine.

- `ST_IDLE` is entered after any reset.
- Leaving `ST_IDLE` is the transition *start*. It fires on the first frame start seen with the run bit set.
- Every frame start seen in `ST_PLAY` or `ST_HOLD` triggers the transition *decide*.
  - If the pause bit is set, *decide* goes to `ST_HOLD`.
  - Otherwise, if skip is requested with a nonzero count, it goes to `ST_SKIP`.
  - Otherwise, if a block pause is requested with a nonzero count, it goes to `ST_BLKP`.
  - Otherwise it goes to `ST_PLAY`.
- The transition *skip_done* fires at the frame start after the last discarded frame. It clears the skip bit, and a *decide* that ignores skip runs in the same cycle.
- The transition *blk_done* fires on the last counted block tick. It clears the block-pause bit and returns to `ST_PLAY` within the current frame.
- The transition *soft_reset* returns any state to `ST_IDLE`.

Top module: `fsmp_ctrl`

## Requirements
- R1: After a hardware or soft reset, decode_en, frame_discard, stall and mute_req are 0. The machine stays in `ST_IDLE` until the run bit is 1 and a frame start arrives. That frame start is seen one cycle after the write at the earliest.
- R2: Writing 1 to bit 0 at address 0x72 sets the run bit, and a register write can never clear it. A soft_reset pulse clears the run bit, the command byte and the count to 0 on the next cycle.
- R3: The run bit reads at address 0x72 bit 0. The command byte is at 0x73, with bit 0 = soft mute A, bit 1 = skip, bit 2 = block pause, bit 3 = pause and bit 5 = mute B. The count is at 0x74. Command bits 4, 6 and 7 always read 0, and writes to them are ignored. Any other address reads 0.
- R4: The command byte is acted on only at a frame start. A write in the middle of a frame changes no output until the next frame start.
- R5: If either mute bit was set at the frame start of a decoded frame, mute_req is 1 together with decode_en for that frame. If both were 0, mute_req is 0.
- R6: With skip set and count N > 0 at a frame start, frame_discard is 1 and decode_en is 0 for N whole frames. At the following frame start the skip bit clears and normal selection resumes.
- R7: With block pause set and count N > 0 at a frame start, stall is 1 until N block ticks have arrived. After that, decode_en is 1 in the same frame and the block-pause bit clears.
- R8: A set pause bit at a frame start gives stall = 1 and decode_en = 0. Decoding resumes at the first frame start after the bit is cleared. Pause outranks skip and block pause.
- R9: When skip and block pause are both set, skip runs first. A count of 0 turns both into no-ops and leaves their bits set.
- R10: While compressed_mode is 1 at a frame start, the skip, block-pause and mute bits have no effect.
- R11: At most one of decode_en, frame_discard and stall is 1 in any cycle, and mute_req is 1 only together with decode_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| sw_reset | input | 1 | Soft reset command pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| frame_start | input | 1 | One-cycle strobe at each frame boundary |
| block_tick | input | 1 | One-cycle strobe per block time |
| compressed_mode | input | 1 | Decode mode in which the commands are unsupported |
| decode_en | output | 1 | Decoder may decode the current frame |
| frame_discard | output | 1 | Current frame is thrown away |
| stall | output | 1 | Decoder is held stopped |
| mute_req | output | 1 | Soft-mute request for the decoded output |

## Verification
Directed sequences exercise one command at a time.

- A mute write in mid-frame separates acting on the command at the frame boundary from acting on it at once.
- Skip and block-pause runs with counts of 3, 2 and 0 separate frame counting from tick counting, and show the zero-count no-op.
- Setting skip and block pause together shows their order.
- A pause that is cleared mid-frame shows that resumption waits for the boundary.
- Compressed mode with every command set shows that the commands are blocked in that mode.

A long seeded random phase then mixes writes, including writes to reserved bits and the run bit, irregular frame and tick strobes, mode changes and soft resets. It checks every cycle against a bench model, which shows up ordering mistakes, such as a write colliding with a self-clear, that the directed cases cannot reach.

// File: rtl/fsmp_pkg.sv
package fsmp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAY,
        ST_SKIP,
        ST_BLKP,
        ST_HOLD
    } fsmp_state_t;

    localparam int BIT_MUTE_A = 0;
    localparam int BIT_SKIP   = 1;
    localparam int BIT_BLK    = 2;
    localparam int BIT_PAUSE  = 3;
    localparam int BIT_MUTE_B = 5;

    localparam logic [7:0] CMD_MASK = 8'h2F;
    localparam logic [7:0] ADR_RUN  = 8'h72;
    localparam logic [7:0] ADR_CMD  = 8'h73;
    localparam logic [7:0] ADR_CNT  = 8'h74;
endpackage

// File: rtl/fsmp_regs.sv
module fsmp_regs
    import fsmp_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_reset,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          clr_skip,
    input  logic          clr_blk,
    output logic          run,
    output logic [7:0]    cmd,
    output logic [CW-1:0] count,
    output logic [DW-1:0] rdata
);
    logic [7:0] cmd_d;

    always_comb begin
        cmd_d = cmd;
        if (wr_en && addr == ADR_CMD) cmd_d = wdata[7:0] & CMD_MASK;
        if (clr_skip) cmd_d[BIT_SKIP] = 1'b0;
        if (clr_blk)  cmd_d[BIT_BLK]  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= 1'b0;
            cmd   <= '0;
            count <= '0;
        end else if (sw_reset) begin
            run   <= 1'b0;
            cmd   <= '0;
            count <= '0;
        end else begin
            if (wr_en && addr == ADR_RUN && wdata[0]) run <= 1'b1;
            if (wr_en && addr == ADR_CNT) count <= wdata[CW-1:0];
            cmd <= cmd_d;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_RUN: rdata = DW'(run);
            ADR_CMD: rdata = DW'(cmd);
            ADR_CNT: rdata = DW'(count);
            default: rdata = '0;
        endcase
    end

    // R2: run can only be cleared by soft reset
    a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sw_reset) |=> run);
    // R2: soft reset clears every register
    a_r2_swr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!run && cmd == 8'h00 && count == '0));
    // R3: reserved command bits stay zero
    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd & ~CMD_MASK) == 8'h00);
endmodule

// File: rtl/fsmp_down.sv
module fsmp_down #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          is_zero,
    output logic          is_one
);
    logic [CW-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rem <= '0;
        else if (clr)              rem <= '0;
        else if (load)             rem <= load_val;
        else if (dec && rem != '0) rem <= rem - CW'(1);
    end

    assign is_zero = (rem == '0);
    assign is_one  = (rem == CW'(1));

    // R6: a decrement is never requested at zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr) |-> !is_zero);
endmodule

// File: rtl/fsmp_fsm.sv
module fsmp_fsm
    import fsmp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_reset,
    input  logic          run,
    input  logic [7:0]    cmd,
    input  logic [CW-1:0] count,
    input  logic          frame_start,
    input  logic          block_tick,
    input  logic          compressed_mode,
    input  logic          cnt_zero,
    input  logic          cnt_one,
    output logic          ld,
    output logic [CW-1:0] ld_val,
    output logic          dec,
    output logic          clr_skip,
    output logic          clr_blk,
    output logic          decode_en,
    output logic          frame_discard,
    output logic          stall,
    output logic          mute_req
);
    fsmp_state_t st, nxt;
    logic        mute_lat, mute_d;
    logic        take, skip_ok, cnt_nz;

    assign cnt_nz = (count != '0);

    always_comb begin
        nxt      = st;
        ld       = 1'b0;
        ld_val   = '0;
        dec      = 1'b0;
        clr_skip = 1'b0;
        clr_blk  = 1'b0;
        take     = 1'b0;
        skip_ok  = 1'b1;
        mute_d   = mute_lat;
        unique case (st)
            ST_IDLE: if (run && frame_start) take = 1'b1;
            ST_PLAY, ST_HOLD: if (frame_start) take = 1'b1;
            ST_SKIP: begin
                if (frame_start) begin
                    if (cnt_zero) begin
                        clr_skip = 1'b1;
                        skip_ok  = 1'b0;
                        take     = 1'b1;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            ST_BLKP: begin
                if (block_tick) begin
                    if (cnt_one) begin
                        clr_blk = 1'b1;
                        nxt     = ST_PLAY;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (take) begin
            mute_d = !compressed_mode && (cmd[BIT_MUTE_A] || cmd[BIT_MUTE_B]);
            if (cmd[BIT_PAUSE]) begin
                nxt = ST_HOLD;
            end else if (!compressed_mode && skip_ok && cmd[BIT_SKIP] && cnt_nz) begin
                nxt    = ST_SKIP;
                ld     = 1'b1;
                ld_val = count - CW'(1);
            end else if (!compressed_mode && cmd[BIT_BLK] && cnt_nz) begin
                nxt    = ST_BLKP;
                ld     = 1'b1;
                ld_val = count;
            end else begin
                nxt = ST_PLAY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            mute_lat <= 1'b0;
        end else if (sw_reset) begin
            st       <= ST_IDLE;
            mute_lat <= 1'b0;
        end else begin
            st       <= nxt;
            mute_lat <= mute_d;
        end
    end

    always_comb begin
        decode_en     = 1'b0;
        frame_discard = 1'b0;
        stall         = 1'b0;
        mute_req      = 1'b0;
        unique case (st)
            ST_PLAY: begin
                decode_en = 1'b1;
                mute_req  = mute_lat;
            end
            ST_SKIP:          frame_discard = 1'b1;
            ST_BLKP, ST_HOLD: stall = 1'b1;
            default: ;
        endcase
    end

    // R11: the decoder controls are mutually exclusive
    a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({decode_en, frame_discard, stall}));
    // R5: mute only accompanies decoding
    a_r5_mute_with_decode: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |-> decode_en);
    // R4: leaving play needs a frame boundary
    a_r4_play_exit_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_PLAY && st != ST_PLAY && !$past(sw_reset)) |-> $past(frame_start));
    // R6: a skip run starts only at a frame boundary
    a_r6_skip_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP && $past(st) != ST_SKIP) |-> $past(frame_start));
    // R7: a block pause ends only on a block tick
    a_r7_blk_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_BLKP && st == ST_PLAY) |-> $past(block_tick));
    // R10: compressed mode blocks skip and block pause
    a_r10_comp_block: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && compressed_mode && st == ST_PLAY && !sw_reset)
            |=> (st == ST_PLAY || st == ST_HOLD));
endmodule

// File: rtl/fsmp_ctrl.sv
module fsmp_ctrl
    import fsmp_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_reset,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          frame_start,
    input  logic          block_tick,
    input  logic          compressed_mode,
    output logic          decode_en,
    output logic          frame_discard,
    output logic          stall,
    output logic          mute_req
);
    logic          run;
    logic [7:0]    cmd;
    logic [CW-1:0] count;
    logic          clr_skip, clr_blk;
    logic          ld, dec, cnt_zero, cnt_one;
    logic [CW-1:0] ld_val;

    fsmp_regs #(.DW(DW), .CW(CW)) regs_i (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .clr_skip(clr_skip), .clr_blk(clr_blk),
        .run(run), .cmd(cmd), .count(count), .rdata(reg_rdata)
    );

    fsmp_down #(.CW(CW)) down_i (
        .clk(clk), .rst_n(rst_n), .clr(sw_reset),
        .load(ld), .load_val(ld_val), .dec(dec),
        .is_zero(cnt_zero), .is_one(cnt_one)
    );

    fsmp_fsm #(.CW(CW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .run(run), .cmd(cmd), .count(count),
        .frame_start(frame_start), .block_tick(block_tick),
        .compressed_mode(compressed_mode),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one),
        .ld(ld), .ld_val(ld_val), .dec(dec),
        .clr_skip(clr_skip), .clr_blk(clr_blk),
        .decode_en(decode_en), .frame_discard(frame_discard),
        .stall(stall), .mute_req(mute_req)
    );

    // R1: nothing reaches the decoder before run is set
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!decode_en && !frame_discard && !stall && !mute_req));
endmodule

// File: tb/fsmp_ctrl_tb.sv
module fsmp_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       frame_start = 1'b0;
    logic       block_tick = 1'b0;
    logic       compressed_mode = 1'b0;
    logic       decode_en, frame_discard, stall, mute_req;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // model state: 0 idle, 1 play, 2 skip, 3 block pause, 4 hold
    int       m_st;
    bit       m_run, m_mute;
    bit [7:0] m_cmd, m_cnt, m_rem;

    always #4 clk = ~clk;

    fsmp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_start(frame_start),
        .block_tick(block_tick), .compressed_mode(compressed_mode),
        .decode_en(decode_en), .frame_discard(frame_discard),
        .stall(stall), .mute_req(mute_req)
    );

    task automatic model_clear();
        m_st = 0; m_run = 0; m_mute = 0; m_cmd = 0; m_cnt = 0; m_rem = 0;
    endtask

    task automatic model_decide(input bit skip_ok);
        m_mute = !compressed_mode && (m_cmd[0] || m_cmd[5]);
        if (m_cmd[3]) m_st = 4;
        else if (!compressed_mode && skip_ok && m_cmd[1] && m_cnt != 0) begin
            m_st = 2; m_rem = m_cnt - 8'd1;
        end else if (!compressed_mode && m_cmd[2] && m_cnt != 0) begin
            m_st = 3; m_rem = m_cnt;
        end else m_st = 1;
    endtask

    task automatic model_tick();
        bit cs, cb;
        cs = 0; cb = 0;
        if (sw_reset) begin
            model_clear();
            return;
        end
        case (m_st)
            0: if (m_run && frame_start) model_decide(1'b1);
            1, 4: if (frame_start) model_decide(1'b1);
            2: if (frame_start) begin
                   if (m_rem == 0) begin cs = 1; model_decide(1'b0); end
                   else m_rem = m_rem - 8'd1;
               end
            3: if (block_tick) begin
                   if (m_rem == 1) begin cb = 1; m_st = 1; end
                   else m_rem = m_rem - 8'd1;
               end
            default: m_st = 0;
        endcase
        if (reg_wr) begin
            if (reg_addr == 8'h72 && reg_wdata[0]) m_run = 1;
            if (reg_addr == 8'h73) m_cmd = reg_wdata & 8'h2F;
            if (reg_addr == 8'h74) m_cnt = reg_wdata;
        end
        if (cs) m_cmd[1] = 1'b0;
        if (cb) m_cmd[2] = 1'b0;
    endtask

    function automatic bit [7:0] exp_rdata();
        case (reg_addr)
            8'h72:   return {7'b0, m_run};
            8'h73:   return m_cmd;
            8'h74:   return m_cnt;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit [3:0] exp_outs();
        return {m_st == 1, m_st == 2, m_st == 3 || m_st == 4, m_st == 1 && m_mute};
    endfunction

    task automatic compare();
        bit [3:0] act, exp;
        act = {decode_en, frame_discard, stall, mute_req};
        exp = exp_outs();
        n_chk++;
        if (act !== exp || reg_rdata !== exp_rdata()) begin
            n_fail++;
            $display("FAIL %s: outs/rdata actual %b/%h expected %b/%h (t=%0t)",
                     tag, act, reg_rdata, exp, exp_rdata(), $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare();
        reg_wr = 0; frame_start = 0; block_tick = 0; sw_reset = 0;
    endtask

    task automatic wr(input bit [7:0] a, input bit [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic rd(input bit [7:0] a);
        reg_addr = a;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic frame(input int len, input int tick_every);
        frame_start = 1;
        step();
        for (int i = 1; i < len; i++) begin
            block_tick = (i % tick_every == 0);
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state and idle with frame starts but no run
        tag = "R1"; rd(8'h72); rd(8'h73); rd(8'h74);
        frame(4, 2); frame(4, 2);
        // R2 run is sticky
        tag = "R2"; wr(8'h72, 8'h01); wr(8'h72, 8'h00); rd(8'h72);
        // R1 first decoded frame after run
        tag = "R1"; frame(4, 2);
        // R4 / R5 mid-frame mute write waits for the boundary
        tag = "R4"; wr(8'h73, 8'h01); idle(3);
        tag = "R5"; frame(4, 2); wr(8'h73, 8'h20); frame(4, 2);
        wr(8'h73, 8'h00); frame(4, 2);
        // R6 skip three frames
        tag = "R6"; wr(8'h74, 8'd3); wr(8'h73, 8'h02);
        for (int f = 0; f < 5; f++) frame(4, 2);
        rd(8'h73);
        // R7 block pause two ticks
        tag = "R7"; wr(8'h74, 8'd2); wr(8'h73, 8'h04);
        frame(8, 2); frame(4, 2); rd(8'h73);
        // R8 pause held, cleared mid-frame, resumes at boundary
        tag = "R8"; wr(8'h73, 8'h0E); frame(4, 2); frame(4, 2);
        wr(8'h73, 8'h00); idle(3); frame(4, 2);
        // R9 skip before block pause, then zero count no-op
        tag = "R9"; wr(8'h74, 8'd2); wr(8'h73, 8'h06);
        for (int f = 0; f < 4; f++) frame(8, 2);
        wr(8'h74, 8'd0); wr(8'h73, 8'h06); frame(4, 2); frame(4, 2); rd(8'h73);
        // R10 compressed mode blocks commands
        tag = "R10"; compressed_mode = 1; wr(8'h74, 8'd2); wr(8'h73, 8'h27);
        frame(6, 2); frame(6, 2); compressed_mode = 0;
        wr(8'h73, 8'h00); frame(4, 2);
        // R3 reserved bits and unmapped address
        tag = "R3"; wr(8'h73, 8'hD0); rd(8'h73); rd(8'h75); wr(8'h73, 8'h00);
        // R2 soft reset clears everything
        tag = "R2"; wr(8'h74, 8'd5); sw_reset = 1; step();
        rd(8'h72); rd(8'h74); frame(4, 2);
        wr(8'h72, 8'h01);
        // R11 random phase
        tag = "R11";
        for (int c = 0; c < 6000; c++) begin
            frame_start = ($urandom % 10 == 0);
            block_tick  = ($urandom % 3 == 0);
            if ($urandom % 60 == 0) compressed_mode = ~compressed_mode;
            sw_reset = ($urandom % 500 == 0);
            if ($urandom % 20 == 0) begin
                bit [7:0] d;
                reg_wr = 1;
                reg_addr = 8'h72 + 8'($urandom % 3);
                d = 8'($urandom);
                if (reg_addr == 8'h73 && d[3] && ($urandom % 4 != 0)) d[3] = 1'b0;
                if (reg_addr == 8'h74) d = 8'($urandom % 5);
                reg_wdata = d;
            end else begin
                reg_addr = 8'h71 + 8'($urandom % 4);
            end
            step();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule